// File: doc/BRIEF.md
# AXI Address Request Legality Checker

This block watches one AXI address channel, either write or read, and judges every request at the cycle of its handshake against the limits the interface was built with. Those limits are the data bus width, the largest number of bytes one transaction may move, whether FIXED bursts are allowed, and an optional "regular transactions" profile. The regular profile restricts burst lengths, requires full-width beats for multi-beat bursts, and requires naturally aligned addresses. The block also applies the atomic-operation size limit on the write channel and the memory-tag operation rules on both channels.

Each rule has its own violation bit. A bit is registered from the handshake cycle and is high for exactly the one cycle that follows it. In every other cycle all bits are low. The block never stalls or alters the channel, so it can sit beside any manager or subordinate port as a passive monitor.

Top module: `axreq_legality_chk`

## Requirements
- R1: After reset, and in every cycle that does not directly follow a handshake (valid and ready both high at a rising edge), `viol_o` is all zero. A request that is valid without ready raises nothing.
- R2: Bit 0 is set when 2^size exceeds `DATA_BYTES`.
- R3: Bit 1 is set when (len+1)·2^size exceeds `MAX_XFER_BYTES`. A total equal to the limit is legal.
- R4: Bit 2 is set when the burst code is FIXED (2'b00) and either `FIXED_OFF` or `REGULAR_ONLY` is 1. INCR is 2'b01 and WRAP is 2'b10.
- R5: With `REGULAR_ONLY`, bit 3 is set when len is not one of 0, 1, 3, 7 or 15.
- R6: With `REGULAR_ONLY`, bit 4 is set when len is non-zero and 2^size differs from `DATA_BYTES`.
- R7: With `REGULAR_ONLY` and a legal length, an INCR request sets bit 5 when the address is not a multiple of the total burst bytes.
- R8: With `REGULAR_ONLY`, a WRAP request sets bit 5 when the address is not a multiple of 2^size.
- R9: On a write-channel instance (`IS_WRITE`=1), bit 6 is set when atop is non-zero and size is above 5. A read-channel instance ignores atop.
- R10: When tagop is non-zero, bit 7 flags a FIXED burst, bit 8 flags a cache value other than 4'b0011, and bit 9 flags a unique-ID flag of 0.
- R11: On a read-channel instance, bit 10 is set when tagop is 2'b10. A write-channel instance never sets bit 10.
- R12: With `REGULAR_ONLY`=0, bits 3, 4 and 5 stay clear whatever the length, size or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Address channel valid |
| req_ready_i | input | 1 | Address channel ready |
| req_addr_i | input | ADDR_W | Request start address |
| req_len_i | input | 8 | Beats minus one |
| req_size_i | input | 3 | Log2 of bytes per beat |
| req_burst_i | input | 2 | Burst code (FIXED 0, INCR 1, WRAP 2) |
| req_cache_i | input | 4 | Cache attribute |
| req_atop_i | input | 6 | Atomic operation code (write channel) |
| req_tagop_i | input | 2 | Memory tag operation |
| req_idunq_i | input | 1 | Unique-ID flag |
| viol_o | output | 11 | One registered violation bit per rule |

## Verification
Two instances are driven: a write checker in the regular profile and a read checker with FIXED disabled and a small byte limit. A shared table sends each of them legal requests and requests that break one rule or several. Requests that break several rules at once show that the flags are independent and do not mask each other. Boundary requests sit exactly at each limit: a total equal to the byte limit, an atomic size of 5, a one-byte transfer at an odd address, and a reserved tag code on the write side. These tell a correct comparison from an off-by-one. Directed sequences cover reset, valid without ready, back-to-back handshakes, and the one-cycle width of each flag.

// File: rtl/axreq_pkg.sv
package axreq_pkg;

    localparam int LEN_W   = 8;
    localparam int SIZE_W  = 3;
    localparam int BURST_W = 2;
    localparam int CACHE_W = 4;
    localparam int ATOP_W  = 6;
    localparam int TAGOP_W = 2;

    // widest total byte count: 256 beats of 128 bytes
    localparam int TOT_W = LEN_W + 1 + (2 ** SIZE_W) - 1;

    localparam int                 REG_LEN_LIMIT   = 15;
    localparam int                 ATOMIC_MAX_SIZE = 5;
    localparam logic [CACHE_W-1:0] TAG_CACHE_REQ   = 4'b0011;
    localparam logic [TAGOP_W-1:0] TAGOP_RESERVED  = 2'b10;

    typedef enum logic [BURST_W-1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;

    // violation bit positions
    localparam int RULE_SIZE      = 0;
    localparam int RULE_BYTES     = 1;
    localparam int RULE_FIXED     = 2;
    localparam int RULE_LEN       = 3;
    localparam int RULE_WIDTH     = 4;
    localparam int RULE_ALIGN     = 5;
    localparam int RULE_ATOMIC    = 6;
    localparam int RULE_TAG_BURST = 7;
    localparam int RULE_TAG_CACHE = 8;
    localparam int RULE_TAG_UNIQ  = 9;
    localparam int RULE_TAG_RSVD  = 10;
    localparam int NUM_RULES      = 11;

    typedef struct packed {
        logic [LEN_W-1:0]   len;
        logic [SIZE_W-1:0]  size;
        burst_e             burst;
        logic [CACHE_W-1:0] cache;
        logic [ATOP_W-1:0]  atop;
        logic [TAGOP_W-1:0] tagop;
        logic               idunq;
    } req_attr_t;

    typedef struct packed {
        logic [NUM_RULES-1:0] viol;
    } chk_state_t;

endpackage

// File: rtl/axreq_geom.sv
module axreq_geom
    import axreq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  req_attr_t         attr_i,
    output logic [TOT_W-1:0]  total_bytes_o,
    output logic              len_regular_o,
    output logic              incr_misaligned_o,
    output logic              wrap_misaligned_o
);

    logic [TOT_W-1:0]  total_bytes;
    logic [ADDR_W-1:0] beat_mask;
    logic [ADDR_W-1:0] burst_mask;
    logic              len_regular;

    always_comb begin
        total_bytes = (TOT_W'(attr_i.len) + TOT_W'(1)) << attr_i.size;

        // len+1 is a power of two and no more than the regular limit
        len_regular = ((attr_i.len & (attr_i.len + LEN_W'(1))) == '0) &&
                      (attr_i.len <= LEN_W'(REG_LEN_LIMIT));

        beat_mask  = (ADDR_W'(1) << attr_i.size) - ADDR_W'(1);
        burst_mask = ADDR_W'(total_bytes) - ADDR_W'(1);
    end

    assign total_bytes_o     = total_bytes;
    assign len_regular_o     = len_regular;
    assign incr_misaligned_o = len_regular && ((addr_i & burst_mask) != '0);
    assign wrap_misaligned_o = (addr_i & beat_mask) != '0;

endmodule

// File: rtl/axreq_limit_rules.sv
module axreq_limit_rules
    import axreq_pkg::*;
#(
    parameter int DATA_BYTES     = 8,
    parameter int MAX_XFER_BYTES = 4096,
    parameter bit FIXED_OFF      = 1'b0,
    parameter bit REGULAR_ONLY   = 1'b1
) (
    input  req_attr_t        attr_i,
    input  logic [TOT_W-1:0] total_bytes_i,
    input  logic             len_regular_i,
    input  logic             incr_misaligned_i,
    input  logic             wrap_misaligned_i,
    output logic             size_bad_o,
    output logic             bytes_bad_o,
    output logic             fixed_bad_o,
    output logic             len_bad_o,
    output logic             width_bad_o,
    output logic             align_bad_o
);

    localparam int                  LOG2_DB = $clog2(DATA_BYTES);
    localparam logic [SIZE_W-1:0]   FULL_SZ = SIZE_W'(LOG2_DB);
    localparam logic [TOT_W:0]      MAX_V   = (TOT_W + 1)'(MAX_XFER_BYTES);

    assign size_bad_o  = attr_i.size > FULL_SZ;
    assign bytes_bad_o = {1'b0, total_bytes_i} > MAX_V;

    generate
        if (FIXED_OFF || REGULAR_ONLY) begin : g_fixed_chk
            assign fixed_bad_o = attr_i.burst == BURST_FIXED;
        end else begin : g_fixed_ok
            assign fixed_bad_o = 1'b0;
        end

        if (REGULAR_ONLY) begin : g_regular
            logic align_bad;
            always_comb begin
                unique case (attr_i.burst)
                    BURST_INCR: align_bad = incr_misaligned_i;
                    BURST_WRAP: align_bad = wrap_misaligned_i;
                    default:    align_bad = 1'b0;
                endcase
            end
            assign len_bad_o   = !len_regular_i;
            assign width_bad_o = (attr_i.len != '0) && (attr_i.size != FULL_SZ);
            assign align_bad_o = align_bad;
        end else begin : g_free
            assign len_bad_o   = 1'b0;
            assign width_bad_o = 1'b0;
            assign align_bad_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/axreq_tag_rules.sv
module axreq_tag_rules
    import axreq_pkg::*;
#(
    parameter bit IS_WRITE = 1'b1
) (
    input  req_attr_t attr_i,
    output logic      atomic_bad_o,
    output logic      tag_burst_bad_o,
    output logic      tag_cache_bad_o,
    output logic      tag_uniq_bad_o,
    output logic      tag_rsvd_bad_o
);

    logic tag_active;

    assign tag_active      = attr_i.tagop != '0;
    assign tag_burst_bad_o = tag_active && (attr_i.burst == BURST_FIXED);
    assign tag_cache_bad_o = tag_active && (attr_i.cache != TAG_CACHE_REQ);
    assign tag_uniq_bad_o  = tag_active && !attr_i.idunq;

    generate
        if (IS_WRITE) begin : g_write
            assign atomic_bad_o   = (attr_i.atop != '0) &&
                                    (attr_i.size > SIZE_W'(ATOMIC_MAX_SIZE));
            assign tag_rsvd_bad_o = 1'b0;
        end else begin : g_read
            assign atomic_bad_o   = 1'b0;
            assign tag_rsvd_bad_o = attr_i.tagop == TAGOP_RESERVED;
        end
    endgenerate

endmodule

// File: rtl/axreq_legality_chk.sv
module axreq_legality_chk
    import axreq_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int DATA_BYTES     = 8,
    parameter int MAX_XFER_BYTES = 4096,
    parameter bit IS_WRITE       = 1'b1,
    parameter bit FIXED_OFF      = 1'b0,
    parameter bit REGULAR_ONLY   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  logic                 req_ready_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [7:0]           req_len_i,
    input  logic [2:0]           req_size_i,
    input  logic [1:0]           req_burst_i,
    input  logic [3:0]           req_cache_i,
    input  logic [5:0]           req_atop_i,
    input  logic [1:0]           req_tagop_i,
    input  logic                 req_idunq_i,
    output logic [NUM_RULES-1:0] viol_o
);

    localparam int LOG2_DB = $clog2(DATA_BYTES);

    req_attr_t        attr;
    logic             hs;
    logic [TOT_W-1:0] total_bytes;
    logic             len_regular;
    logic             incr_mis;
    logic             wrap_mis;
    logic [NUM_RULES-1:0] flags;
    chk_state_t       state_d, state_q;

    always_comb begin
        attr.len   = req_len_i;
        attr.size  = req_size_i;
        attr.burst = burst_e'(req_burst_i);
        attr.cache = req_cache_i;
        attr.atop  = req_atop_i;
        attr.tagop = req_tagop_i;
        attr.idunq = req_idunq_i;
    end

    assign hs = req_valid_i && req_ready_i;

    axreq_geom #(
        .ADDR_W (ADDR_W)
    ) u_geom (
        .addr_i            (req_addr_i),
        .attr_i            (attr),
        .total_bytes_o     (total_bytes),
        .len_regular_o     (len_regular),
        .incr_misaligned_o (incr_mis),
        .wrap_misaligned_o (wrap_mis)
    );

    axreq_limit_rules #(
        .DATA_BYTES     (DATA_BYTES),
        .MAX_XFER_BYTES (MAX_XFER_BYTES),
        .FIXED_OFF      (FIXED_OFF),
        .REGULAR_ONLY   (REGULAR_ONLY)
    ) u_limits (
        .attr_i            (attr),
        .total_bytes_i     (total_bytes),
        .len_regular_i     (len_regular),
        .incr_misaligned_i (incr_mis),
        .wrap_misaligned_i (wrap_mis),
        .size_bad_o        (flags[RULE_SIZE]),
        .bytes_bad_o       (flags[RULE_BYTES]),
        .fixed_bad_o       (flags[RULE_FIXED]),
        .len_bad_o         (flags[RULE_LEN]),
        .width_bad_o       (flags[RULE_WIDTH]),
        .align_bad_o       (flags[RULE_ALIGN])
    );

    axreq_tag_rules #(
        .IS_WRITE (IS_WRITE)
    ) u_tags (
        .attr_i          (attr),
        .atomic_bad_o    (flags[RULE_ATOMIC]),
        .tag_burst_bad_o (flags[RULE_TAG_BURST]),
        .tag_cache_bad_o (flags[RULE_TAG_CACHE]),
        .tag_uniq_bad_o  (flags[RULE_TAG_UNIQ]),
        .tag_rsvd_bad_o  (flags[RULE_TAG_RSVD])
    );

    always_comb begin
        state_d      = state_q;
        state_d.viol = hs ? flags : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign viol_o = state_q.viol;

    // R1: nothing is reported unless the previous edge saw a handshake
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hs |=> (viol_o == '0));

    // R2: oversize beat is always flagged
    p_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && (req_size_i > 3'(LOG2_DB))) |=> viol_o[RULE_SIZE]);

    // R10: tag operation without the unique-ID flag
    p_tag_uniq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && (req_tagop_i != 2'b00) && !req_idunq_i) |=> viol_o[RULE_TAG_UNIQ]);

    // R3: a burst that fits in the byte limit is never flagged for size
    p_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && (((32'(req_len_i) + 32'd1) << req_size_i) <= 32'(MAX_XFER_BYTES)))
        |=> !viol_o[RULE_BYTES]);

    generate
        if (FIXED_OFF || REGULAR_ONLY) begin : g_fixed_prop
            // R4: FIXED burst under a profile that forbids it
            p_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (hs && (req_burst_i == 2'b00)) |=> viol_o[RULE_FIXED]);
        end
        if (REGULAR_ONLY) begin : g_reg_prop
            // R5: a length of three beats is never regular
            p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (hs && (req_len_i == 8'd2)) |=> viol_o[RULE_LEN]);
        end else begin : g_free_prop
            // R12: regular-profile bits stay low
            p_free_r12: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (viol_o[RULE_ALIGN:RULE_LEN] == 3'b000));
        end
        if (!IS_WRITE) begin : g_rd_prop
            // R9: atomic code is ignored on a read channel
            p_no_atomic_r9: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> !viol_o[RULE_ATOMIC]);
        end else begin : g_wr_prop
            // R11: reserved tag code is only a read-channel rule
            p_no_rsvd_r11: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> !viol_o[RULE_TAG_RSVD]);
        end
    endgenerate

endmodule

// File: tb/axreq_legality_chk_bench.sv
module axreq_legality_chk_bench;

    typedef struct packed {
        logic        rd;
        logic [31:0] addr;
        logic [7:0]  len;
        logic [2:0]  size;
        logic [1:0]  burst;
        logic [3:0]  cache;
        logic [5:0]  atop;
        logic [1:0]  tagop;
        logic        idunq;
        logic [10:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam logic [1:0] FX = 2'b00, IN = 2'b01, WR = 2'b10;
    localparam int NV = 26;

    localparam vec_t TABLE [NV] = '{
        '{1'b0, 32'h1000, 8'd3,   3'd3, IN, 4'h0, 6'h00, 2'd0, 1'b0, 11'h000, 4'd7 },  // R7 aligned
        '{1'b0, 32'h1000, 8'd0,   3'd4, IN, 4'h0, 6'h00, 2'd0, 1'b0, 11'h001, 4'd2 },  // R2
        '{1'b0, 32'h1000, 8'd15,  3'd3, IN, 4'h0, 6'h00, 2'd0, 1'b0, 11'h000, 4'd5 },  // R5 longest
        '{1'b0, 32'h0000, 8'd255, 3'd3, IN, 4'h0, 6'h00, 2'd0, 1'b0, 11'h008, 4'd5 },  // R5
        '{1'b0, 32'h0000, 8'd255, 3'd5, IN, 4'h0, 6'h00, 2'd0, 1'b0, 11'h01B, 4'd3 },  // R3 multi
        '{1'b0, 32'h0000, 8'd0,   3'd3, FX, 4'h0, 6'h00, 2'd0, 1'b0, 11'h004, 4'd4 },  // R4
        '{1'b0, 32'h0000, 8'd1,   3'd2, IN, 4'h0, 6'h00, 2'd0, 1'b0, 11'h010, 4'd6 },  // R6
        '{1'b0, 32'h1020, 8'd7,   3'd3, IN, 4'h0, 6'h00, 2'd0, 1'b0, 11'h020, 4'd7 },  // R7
        '{1'b0, 32'h1008, 8'd3,   3'd3, WR, 4'h0, 6'h00, 2'd0, 1'b0, 11'h000, 4'd8 },  // R8 ok
        '{1'b0, 32'h1004, 8'd3,   3'd3, WR, 4'h0, 6'h00, 2'd0, 1'b0, 11'h020, 4'd8 },  // R8
        '{1'b0, 32'h1003, 8'd0,   3'd0, IN, 4'h0, 6'h00, 2'd0, 1'b0, 11'h000, 4'd7 },  // R7 byte
        '{1'b0, 32'h1000, 8'd0,   3'd6, IN, 4'h0, 6'h20, 2'd0, 1'b0, 11'h041, 4'd9 },  // R9
        '{1'b0, 32'h1000, 8'd0,   3'd5, IN, 4'h0, 6'h01, 2'd0, 1'b0, 11'h001, 4'd9 },  // R9 edge
        '{1'b0, 32'h1000, 8'd0,   3'd3, IN, 4'h3, 6'h00, 2'd1, 1'b1, 11'h000, 4'd10},  // R10 ok
        '{1'b0, 32'h1000, 8'd0,   3'd3, FX, 4'h3, 6'h00, 2'd1, 1'b1, 11'h084, 4'd10},  // R10
        '{1'b0, 32'h1000, 8'd0,   3'd3, IN, 4'h7, 6'h00, 2'd3, 1'b1, 11'h100, 4'd10},  // R10
        '{1'b0, 32'h1000, 8'd0,   3'd3, IN, 4'h3, 6'h00, 2'd2, 1'b0, 11'h200, 4'd10},  // R10
        '{1'b0, 32'h1000, 8'd0,   3'd3, FX, 4'hF, 6'h00, 2'd0, 1'b0, 11'h004, 4'd10},  // R10 idle
        '{1'b0, 32'h1000, 8'd0,   3'd3, IN, 4'h3, 6'h00, 2'd2, 1'b1, 11'h000, 4'd11},  // R11 write
        '{1'b1, 32'h0000, 8'd0,   3'd3, IN, 4'h3, 6'h00, 2'd2, 1'b1, 11'h400, 4'd11},  // R11
        '{1'b1, 32'h0000, 8'd0,   3'd6, IN, 4'h0, 6'h3F, 2'd0, 1'b0, 11'h001, 4'd9 },  // R9 read
        '{1'b1, 32'h0003, 8'd2,   3'd2, IN, 4'h0, 6'h00, 2'd0, 1'b0, 11'h000, 4'd12},  // R12
        '{1'b1, 32'h0004, 8'd1,   3'd2, WR, 4'h0, 6'h00, 2'd0, 1'b0, 11'h000, 4'd12},  // R12
        '{1'b1, 32'h0000, 8'd0,   3'd3, FX, 4'h0, 6'h00, 2'd0, 1'b0, 11'h004, 4'd4 },  // R4 read
        '{1'b1, 32'h0000, 8'd8,   3'd3, IN, 4'h0, 6'h00, 2'd0, 1'b0, 11'h002, 4'd3 },  // R3
        '{1'b1, 32'h0000, 8'd7,   3'd3, IN, 4'h0, 6'h00, 2'd0, 1'b0, 11'h000, 4'd3 }   // R3 edge
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_w = 1'b0, valid_r = 1'b0, ready = 1'b0;
    logic [31:0] addr = '0;
    logic [7:0]  len = '0;
    logic [2:0]  size = '0;
    logic [1:0]  burst = 2'b01;
    logic [3:0]  cache = '0;
    logic [5:0]  atop = '0;
    logic [1:0]  tagop = '0;
    logic        idunq = 1'b0;
    logic [10:0] viol_w, viol_r;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    axreq_legality_chk u_axreq_legality_chk (
        .clk (clk), .rst_n (rst_n),
        .req_valid_i (valid_w), .req_ready_i (ready),
        .req_addr_i (addr), .req_len_i (len), .req_size_i (size),
        .req_burst_i (burst), .req_cache_i (cache), .req_atop_i (atop),
        .req_tagop_i (tagop), .req_idunq_i (idunq), .viol_o (viol_w)
    );

    axreq_legality_chk #(
        .MAX_XFER_BYTES (64), .IS_WRITE (1'b0),
        .FIXED_OFF (1'b1), .REGULAR_ONLY (1'b0)
    ) u_axreq_legality_chk_rd (
        .clk (clk), .rst_n (rst_n),
        .req_valid_i (valid_r), .req_ready_i (ready),
        .req_addr_i (addr), .req_len_i (len), .req_size_i (size),
        .req_burst_i (burst), .req_cache_i (cache), .req_atop_i (atop),
        .req_tagop_i (tagop), .req_idunq_i (idunq), .viol_o (viol_r)
    );

    task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %03h expected %03h", tag, got, exp);
        end
    endtask

    task automatic load(input vec_t v);
        addr = v.addr; len = v.len; size = v.size; burst = v.burst;
        cache = v.cache; atop = v.atop; tagop = v.tagop; idunq = v.idunq;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset write", viol_w, '0);
        check("R1 reset read", viol_r, '0);
        rst_n = 1'b1;

        // table walk: each handshake is followed by one idle cycle
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check("R1 idle write", viol_w, '0);
            check("R1 idle read", viol_r, '0);
            load(TABLE[i]);
            valid_w = !TABLE[i].rd;
            valid_r = TABLE[i].rd;
            ready   = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", TABLE[i].req, i),
                  TABLE[i].rd ? viol_r : viol_w, TABLE[i].exp);
            valid_w = 1'b0; valid_r = 1'b0;
        end

        // R1: valid without ready raises nothing
        @(negedge clk);
        load(TABLE[4]);
        valid_w = 1'b1; valid_r = 1'b1; ready = 1'b0;
        @(negedge clk);
        check("R1 no ready write", viol_w, '0);
        check("R1 no ready read", viol_r, '0);

        // R2 then R1: back-to-back handshakes, each verdict one cycle wide
        valid_r = 1'b0; ready = 1'b1;
        load(TABLE[1]);
        @(negedge clk);
        check("R2 back-to-back first", viol_w, 11'h001);
        load(TABLE[0]);
        @(negedge clk);
        check("R1 back-to-back second", viol_w, 11'h000);
        load(TABLE[5]);
        @(negedge clk);
        check("R4 back-to-back third", viol_w, 11'h004);
        valid_w = 1'b0;
        @(negedge clk);
        check("R1 flag one cycle", viol_w, '0);

        // R1: reset in the middle clears a pending flag
        valid_w = 1'b1; load(TABLE[4]);
        @(negedge clk);
        check("R5 before reset", viol_w, 11'h01B);
        valid_w = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", viol_w, '0);
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule